// File: doc/BRIEF.md
# Serial Receiver Configuration Port

This block is a write-only serial slave. It loads the control register file of a radio receiver. A host lowers an active-low select line and clocks a frame in on a serial data line, most significant bit first. The first six bits of the frame are the register address. The last bits before select rises are the data. Any number of filler bits may sit between the two. This lets a host that always sends 24-bit words use the same frames for every register. Nothing is written until select rises again. At that point the data goes into one of five 12-bit registers or into one 18-bit filter/gain register. A special address returns every register to its default value.

The three serial pins are asynchronous to the system clock, so each pin passes through a synchronizer. The block finds serial-clock rising edges and select edges from the synchronized samples. The serial clock must therefore be slow against the system clock. All six registers are presented in parallel. A one-cycle write strobe per register tells downstream logic that a new value has landed.

Top module: `rxcfg_serial_slave`

## Requirements
- R1: While `rst` is high, no strobe fires. On release, `cfg_narrow` slices 0..4 hold 12'h044, 12'h400, 12'h080, 12'h124 and 12'h053, and `cfg_wide` holds 18'h2B030. Slice k is bits [12k+11:12k].
- R2: A frame of address 6'b100000+k (k = 0..4) followed by at least 12 data bits loads register slice k with the last 12 bits. The load happens only after select rises, never while the frame is still open.
- R3: A frame of address 6'b100101 followed by at least 18 data bits loads `cfg_wide` with the last 18 bits shifted in.
- R4: Filler bits between the address and the data, of any value, do not change the loaded data.
- R5: Frames addressed to 6'b100110 or 6'b100111 change no register and raise no strobe.
- R6: A frame addressed to 6'b011111 returns every register to its R1 default and pulses all six strobes once.
- R7: A frame with fewer than 6 plus the data width of its register bits is dropped. No register changes and no strobe fires.
- R8: Each committed write pulses strobe bit k (bit 5 for the wide register) for exactly one system clock. A single-register write raises only that bit.
- R9: Serial-clock edges while select is high shift nothing. A following frame is decoded from its own first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset to defaults |
| sel_n | input | 1 | Active-low frame select, asynchronous |
| ser_clk | input | 1 | Serial bit clock, asynchronous, sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| cfg_narrow | output | 60 | Five 12-bit configuration registers, register k at bits [12k+11:12k] |
| cfg_wide | output | 18 | Filter/gain register |
| cfg_wr | output | 6 | One-cycle write strobe per register, bit 5 for the wide register |

## Verification
The case that is hardest to reach is a frame whose address and data are correct but whose bit alignment is not. Padded frames, truncated frames and stray serial-clock edges while deselected all fall in this group. They can only be told apart by where the data lands. The stimulus therefore sends each register with several filler lengths, using all-ones filler so that a misalignment corrupts the value. It also sends frames that stop a few bits short, and it toggles the serial clock with select high just before a valid frame. Register contents and strobe counts are compared against a model after every frame.

// File: rtl/rxcfg_pkg.sv
package rxcfg_pkg;
  localparam int ADDR_BITS   = 6;
  localparam int N_NARROW    = 5;
  localparam int NARROW_BITS = 12;
  localparam int WIDE_BITS   = 18;

  localparam logic [ADDR_BITS-1:0] BASE_ADDR  = 6'b100000;
  localparam logic [ADDR_BITS-1:0] RESET_ADDR = 6'b011111;

  // field positions that set the defaults
  localparam int CLKBYP_POS = 6;
  localparam int TXSEL_POS  = 2;
  localparam int DCEN_POS   = 10;
  localparam int TMR1_POS   = 2;
  localparam int GCAL_POS   = 0;
  localparam int LNAI_POS   = 3;
  localparam int MIXI_POS   = 5;
  localparam int LSEL_POS   = 15;
  localparam int CGAIN_POS  = 12;
  localparam int SG_A_POS   = 5;
  localparam int SG_B_POS   = 4;

  function automatic logic [11:0] narrow_default(input int idx);
    case (idx)
      0:       return (12'd1 << CLKBYP_POS) | (12'd1 << TXSEL_POS);
      1:       return 12'd1 << DCEN_POS;
      2:       return 12'h020 << TMR1_POS;
      3:       return 12'h124;
      4:       return (12'd3 << GCAL_POS) | (12'd2 << LNAI_POS) | (12'd2 << MIXI_POS);
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic [17:0] wide_default();
    return (18'd5 << LSEL_POS) | (18'd3 << CGAIN_POS) |
           (18'd1 << SG_A_POS) | (18'd1 << SG_B_POS);
  endfunction
endpackage

// File: rtl/rxcfg_pin_sync.sv
module rxcfg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic bit_stb,
  output logic bit_val,
  output logic frm_start,
  output logic frm_end
);
  logic [STAGES-1:0] sel_sr, sck_sr, dat_sr;
  logic sel_d, sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_sr <= '1;
      sck_sr <= '0;
      dat_sr <= '0;
      sel_d  <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      sel_sr <= {sel_sr[STAGES-2:0], sel_n};
      sck_sr <= {sck_sr[STAGES-2:0], ser_clk};
      dat_sr <= {dat_sr[STAGES-2:0], ser_dat};
      sel_d  <= sel_sr[STAGES-1];
      sck_d  <= sck_sr[STAGES-1];
    end
  end

  assign bit_stb   = !sel_sr[STAGES-1] && sck_sr[STAGES-1] && !sck_d;
  assign bit_val   = dat_sr[STAGES-1];
  assign frm_start = !sel_sr[STAGES-1] && sel_d;
  assign frm_end   = sel_sr[STAGES-1] && !sel_d;
endmodule

// File: rtl/rxcfg_deframer.sv
module rxcfg_deframer #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              frm_start,
  input  logic              frm_end,
  output logic              commit,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic [CNT_W-1:0]  nbits
);
  localparam logic [CNT_W-1:0] ADDR_N = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit <= 1'b0;
      addr   <= '0;
      data   <= '0;
      nbits  <= '0;
    end else begin
      commit <= frm_end;
      if (frm_start) begin
        nbits <= '0;
      end else if (bit_stb) begin
        if (nbits != CNT_MAX) nbits <= nbits + 1'b1;
        if (nbits < ADDR_N) addr <= {addr[ADDR_W-2:0], bit_val};
        data <= {data[DATA_W-2:0], bit_val};
      end
    end
  end
endmodule

// File: rtl/rxcfg_regbank.sv
module rxcfg_regbank
  import rxcfg_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_N    = 5,
  parameter int NARROW_W = 12,
  parameter int WIDE_W   = 18,
  parameter int CNT_W    = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      commit,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WIDE_W-1:0]         data,
  input  logic [CNT_W-1:0]          nbits,
  output logic [NUM_N*NARROW_W-1:0] narrow_q,
  output logic [WIDE_W-1:0]         wide_q,
  output logic [NUM_N:0]            wr_stb
);
  localparam logic [CNT_W-1:0] NEED_N = CNT_W'(ADDR_W + NARROW_W);
  localparam logic [CNT_W-1:0] NEED_W = CNT_W'(ADDR_W + WIDE_W);
  localparam logic [CNT_W-1:0] NEED_R = CNT_W'(ADDR_W);
  localparam logic [ADDR_W-1:0] WIDE_ADDR = ADDR_W'(BASE_ADDR) + ADDR_W'(NUM_N);

  logic hit_rst, hit_wide;
  logic [NUM_N-1:0] hit_n;

  assign hit_rst  = commit && (addr == ADDR_W'(RESET_ADDR)) && (nbits >= NEED_R);
  assign hit_wide = commit && (addr == WIDE_ADDR) && (nbits >= NEED_W);

  for (genvar k = 0; k < NUM_N; k++) begin : g_narrow
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR) + ADDR_W'(k);
    localparam logic [NARROW_W-1:0] DFLT = NARROW_W'(narrow_default(k));
    assign hit_n[k] = commit && (addr == MY_ADDR) && (nbits >= NEED_N);

    always_ff @(posedge clk) begin
      if (rst || hit_rst) begin
        narrow_q[k*NARROW_W +: NARROW_W] <= DFLT;
      end else if (hit_n[k]) begin
        narrow_q[k*NARROW_W +: NARROW_W] <= data[NARROW_W-1:0];
      end
      wr_stb[k] <= !rst && (hit_n[k] || hit_rst);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hit_rst) begin
      wide_q <= WIDE_W'(wide_default());
    end else if (hit_wide) begin
      wide_q <= data;
    end
    wr_stb[NUM_N] <= !rst && (hit_wide || hit_rst);
  end
endmodule

// File: rtl/rxcfg_serial_slave.sv
module rxcfg_serial_slave
  import rxcfg_pkg::*;
#(
  parameter int ADDR_W      = ADDR_BITS,
  parameter int NUM_N       = N_NARROW,
  parameter int NARROW_W    = NARROW_BITS,
  parameter int WIDE_W      = WIDE_BITS,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sel_n,
  input  logic                      ser_clk,
  input  logic                      ser_dat,
  output logic [NUM_N*NARROW_W-1:0] cfg_narrow,
  output logic [WIDE_W-1:0]         cfg_wide,
  output logic [NUM_N:0]            cfg_wr
);
  logic bit_stb, bit_val, frm_start, frm_end;
  logic commit;
  logic [ADDR_W-1:0] fr_addr;
  logic [WIDE_W-1:0] fr_data;
  logic [CNT_W-1:0]  fr_cnt;

  rxcfg_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .bit_stb(bit_stb), .bit_val(bit_val), .frm_start(frm_start), .frm_end(frm_end)
  );

  rxcfg_deframer #(.ADDR_W(ADDR_W), .DATA_W(WIDE_W), .CNT_W(CNT_W)) deframe_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_val(bit_val),
    .frm_start(frm_start), .frm_end(frm_end),
    .commit(commit), .addr(fr_addr), .data(fr_data), .nbits(fr_cnt)
  );

  rxcfg_regbank #(.ADDR_W(ADDR_W), .NUM_N(NUM_N), .NARROW_W(NARROW_W),
                  .WIDE_W(WIDE_W), .CNT_W(CNT_W)) bank_i (
    .clk(clk), .rst(rst), .commit(commit), .addr(fr_addr), .data(fr_data),
    .nbits(fr_cnt), .narrow_q(cfg_narrow), .wide_q(cfg_wide), .wr_stb(cfg_wr)
  );
endmodule

// File: rtl/rxcfg_serial_slave_chk.sv
module rxcfg_serial_slave_chk
  import rxcfg_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int NUM_N    = 5,
  parameter int NARROW_W = 12,
  parameter int WIDE_W   = 18,
  parameter int CNT_W    = 7
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_N*NARROW_W-1:0] narrow_q,
  input logic [WIDE_W-1:0]         wide_q,
  input logic [NUM_N:0]            wr_stb,
  input logic                      commit,
  input logic [ADDR_W-1:0]         addr,
  input logic [CNT_W-1:0]          nbits
);
  localparam logic [ADDR_W-1:0] RSV0 = ADDR_W'(BASE_ADDR) + ADDR_W'(NUM_N + 1);
  localparam logic [ADDR_W-1:0] RSV1 = ADDR_W'(BASE_ADDR) + ADDR_W'(NUM_N + 2);
  localparam logic [CNT_W-1:0]  MIN_N = CNT_W'(ADDR_W);

  // R1: no strobe in the cycle after reset was sampled
  a_r1_reset_quiet: assert property (@(posedge clk) $past(rst) |-> wr_stb == '0);

  // R1: wide register holds its default coming out of reset
  a_r1_wide_dflt: assert property (@(posedge clk)
    $past(rst) |-> wide_q == WIDE_W'(wide_default()));

  // R8: single writes raise at most one strobe bit
  a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
    (wr_stb != '1) |-> $onehot0(wr_stb));

  // R2: narrow registers change only alongside their strobe
  for (genvar k = 0; k < NUM_N; k++) begin : g_hold
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !wr_stb[k]) |-> $stable(narrow_q[k*NARROW_W +: NARROW_W]));
  end

  // R3: wide register changes only alongside its strobe
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !wr_stb[NUM_N]) |-> $stable(wide_q));

  // R5: reserved addresses commit nothing
  a_r5_reserved: assert property (@(posedge clk) disable iff (rst)
    (commit && (addr == RSV0 || addr == RSV1)) |=> wr_stb == '0);

  // R7: a frame without a full address commits nothing
  a_r7_short: assert property (@(posedge clk) disable iff (rst)
    (commit && nbits < MIN_N) |=> wr_stb == '0);
endmodule

bind rxcfg_serial_slave rxcfg_serial_slave_chk #(
  .ADDR_W(ADDR_W), .NUM_N(NUM_N), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .narrow_q(cfg_narrow), .wide_q(cfg_wide), .wr_stb(cfg_wr),
  .commit(commit), .addr(fr_addr), .nbits(fr_cnt)
);

// File: tb/rxcfg_serial_slave_tb_top.sv
module rxcfg_serial_slave_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic [59:0] cfg_narrow;
  logic [17:0] cfg_wide;
  logic [5:0]  cfg_wr;

  always #2.5 clk = ~clk;

  rxcfg_serial_slave dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .cfg_narrow(cfg_narrow), .cfg_wide(cfg_wide), .cfg_wr(cfg_wr)
  );

  int nchk = 0;
  int nerr = 0;
  int stb_cnt [6];
  logic [11:0] exp_n [5];
  logic [17:0] exp_w;
  int exp_stb [6];

  localparam logic [11:0] DN [5] = '{12'h044, 12'h400, 12'h080, 12'h124, 12'h053};
  localparam logic [17:0] DW = 18'h2B030;

  localparam int NV = 10;
  localparam logic [5:0]  VADDR [NV] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24,
                                         6'h25, 6'h26, 6'h27, 6'h25, 6'h20};
  localparam int          VPAD  [NV] = '{0, 6, 3, 0, 6, 0, 0, 6, 6, 1};
  localparam logic [17:0] VDATA [NV] = '{18'h00ABC, 18'h005A5, 18'h00FFF, 18'h00001,
                                         18'h007E1, 18'h3C3A5, 18'h00123, 18'h3FFFF,
                                         18'h12345, 18'h00F0F};

  always @(posedge clk)
    for (int k = 0; k < 6; k++) if (cfg_wr[k]) stb_cnt[k]++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_stb();
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin stb_cnt[k] = 0; exp_stb[k] = 0; end
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < 5; k++) chk(req, 32'(cfg_narrow[k*12 +: 12]), 32'(exp_n[k]));
    chk(req, 32'(cfg_wide), 32'(exp_w));
  endtask

  task automatic check_stb(input string req);
    for (int k = 0; k < 6; k++) chk(req, 32'(stb_cnt[k]), 32'(exp_stb[k]));
  endtask

  task automatic shift_bits(input logic [63:0] b, input int n);
    @(negedge clk) sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = b[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic close_frame();
    sel_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [63:0] mk(input logic [5:0] a, input int pad,
                                     input logic [17:0] d, input int dw);
    logic [63:0] f;
    f = 64'(a) << (pad + dw);
    f = f | (((64'd1 << pad) - 64'd1) << dw);
    f = f | (64'(d) & ((64'd1 << dw) - 64'd1));
    return f;
  endfunction

  task automatic set_defaults();
    for (int k = 0; k < 5; k++) exp_n[k] = DN[k];
    exp_w = DW;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    int dw;
    string tag;
    repeat (5) @(negedge clk);
    clr_stb();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    set_defaults();
    check_regs("R1 reset defaults");
    check_stb("R1 no strobe after reset");

    // table-driven frames
    for (int v = 0; v < NV; v++) begin
      dw = (VADDR[v] == 6'h25) ? 18 : 12;
      clr_stb();
      shift_bits(mk(VADDR[v], VPAD[v], VDATA[v], dw), 6 + VPAD[v] + dw);
      close_frame();
      if (VADDR[v] >= 6'h20 && VADDR[v] <= 6'h24) begin
        exp_n[VADDR[v] - 6'h20] = VDATA[v][11:0];
        exp_stb[VADDR[v] - 6'h20] = 1;
        tag = "R2";
      end else if (VADDR[v] == 6'h25) begin
        exp_w = VDATA[v];
        exp_stb[5] = 1;
        tag = "R3";
      end else begin
        tag = "R5";
      end
      if (VPAD[v] > 0) tag = {tag, " R4 padded"};
      check_regs($sformatf("%s vec%0d", tag, v));
      check_stb($sformatf("R8 strobe vec%0d", v));
    end

    // R2: nothing lands while the frame is still open
    clr_stb();
    shift_bits(mk(6'h23, 0, 18'h00BEE, 12), 18);
    check_regs("R2 held until deselect");
    check_stb("R2 no strobe before deselect");
    close_frame();
    exp_n[3] = 12'hBEE; exp_stb[3] = 1;
    check_regs("R2 commit on deselect");
    check_stb("R8 strobe on deselect");

    // R7: truncated frames dropped
    clr_stb();
    shift_bits(mk(6'h21, 0, 18'h00333, 12) >> 2, 16);
    close_frame();
    shift_bits(mk(6'h25, 0, 18'h00777, 18) >> 1, 23);
    close_frame();
    shift_bits(64'h5, 4);
    close_frame();
    check_regs("R7 short frames dropped");
    check_stb("R7 no strobe on short frame");

    // R9: serial clock toggling while deselected
    clr_stb();
    for (int i = 0; i < 20; i++) begin
      ser_dat = i[0];
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (10) @(negedge clk);
    check_regs("R9 idle clocks ignored");
    check_stb("R9 no strobe from idle clocks");
    shift_bits(mk(6'h22, 0, 18'h000F0, 12), 18);
    close_frame();
    exp_n[2] = 12'h0F0; exp_stb[2] = 1;
    check_regs("R9 frame after idle clocks");

    // R6: global reset command
    clr_stb();
    shift_bits(mk(6'h1F, 0, 18'h0, 18), 24);
    close_frame();
    set_defaults();
    for (int k = 0; k < 6; k++) exp_stb[k] = 1;
    check_regs("R6 reset command");
    check_stb("R6 all strobes once");

    // R1: reset pin after fresh writes
    shift_bits(mk(6'h24, 0, 18'h00ABC, 12), 18);
    close_frame();
    shift_bits(mk(6'h25, 0, 18'h11111, 18), 24);
    close_frame();
    clr_stb();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    set_defaults();
    check_regs("R1 reset pin");
    check_stb("R1 reset pin no strobe");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule